// File: doc/BRIEF.md
# Real-Time-Clock Register Front End

This block is the byte-level register interface of a real-time-clock device attached to an I2C bus. A separate bit engine decodes SCL and SDA into single-cycle events and whole bytes, and this block turns them into register accesses. The events are start-for-write, start-for-read, stop, a received data byte, and a request for the next byte to transmit. The block holds a 4-bit register pointer and sixteen byte-wide registers. The first seven registers hold the time fields: seconds, minutes, hours, weekday, day, month and year.

After a start-for-write, the first byte received is an address byte and is not stored. Its upper nibble loads the pointer and its lower nibble is kept as a transfer-format code. Each later byte is handled according to the pointer. A byte aimed at a time field goes out to the timekeeping core as a one-cycle set request. A byte aimed at register 7 or above is stored in the block.

A start-for-read copies all seven live time fields into registers 0 to 6 in the same cycle, so a multi-byte read returns one coherent time value. It also forces the pointer to 0xF. The first byte returned is therefore register 15, after which the read wraps round to the time fields.

Top module: `rtc_regfront`

## Requirements
- R1: After reset all sixteen registers read as zero, the pointer is 0, no address byte is pending, `fmt_code`, `rd_byte` and `set_stb` are zero, and `dev_addr` shows the 7-bit bus address 0x32.
- R2: The first byte received after a start-for-write loads the pointer from its bits 7:4 and drives its bits 3:0 onto `fmt_code` from the next cycle. It raises no set strobe and changes no register.
- R3: A byte received with no address byte pending, while the pointer is 7 to 15, is stored in the register at the pointer and can be read back later.
- R4: A byte received with no address byte pending, while the pointer is 0 to 6, raises `set_stb` for exactly the next cycle. In that cycle `set_idx` equals the pointer and `set_val` equals the byte. The register file is not changed.
- R5: A start-for-read copies `live_time` byte k (bits 8k+7:8k) into register k for k = 0 to 6 and sets the pointer to 15.
- R6: Registers 0 to 6 change only on a start-for-read. A change of `live_time` after the start has no effect on the bytes that are read back.
- R7: The pointer advances by one after every data byte received and after every byte read, and wraps from 15 to 0.
- R8: A stop event clears a pending address byte and leaves the pointer unchanged, so the next received byte is handled as data.
- R9: On `rd_req`, `rd_byte` takes the register at the current pointer from the next cycle onward and holds it until the next `rd_req`.
- R10: If events coincide, one action is taken per cycle in this priority order: start-for-read, start-for-write, stop, received byte, read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | Start condition with the write direction bit |
| ev_rd_start | input | 1 | Start condition with the read direction bit |
| ev_stop | input | 1 | Stop condition |
| wr_valid | input | 1 | A received byte is present on `wr_byte` |
| wr_byte | input | 8 | Received byte |
| rd_req | input | 1 | Bit engine asks for the next byte to transmit |
| rd_byte | output | 8 | Byte to transmit, valid from the cycle after `rd_req` |
| live_time | input | 56 | Live time fields, byte k holds field k |
| set_stb | output | 1 | One-cycle request to load one time field |
| set_idx | output | 3 | Time field to load (0 to 6) |
| set_val | output | 8 | Value for that field |
| fmt_code | output | 4 | Latched transfer-format code |
| dev_addr | output | 7 | 7-bit bus address for the bit engine |

## Verification
The bench sweeps every pointer value through an address byte followed by a data byte. A design that stored time writes locally, or that raised a strobe for local registers, would return the wrong byte on readback or show a stray `set_stb`. Bursts that run across register 15 catch a pointer that saturates or fails to wrap. Changing `live_time` in the middle of a read catches a design that reads the live fields instead of the snapshot. Ending a write with a stop straight after the start checks that a stale pending flag does not swallow the next data byte as an address.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;
    parameter int PTR_W     = 4;
    parameter int BYTE_W    = 8;
    parameter int TIME_REGS = 7;
    parameter int IDX_W     = $clog2(TIME_REGS);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              pend;
        logic [PTR_W-1:0]  fmt;
        logic              set_stb;
        logic [IDX_W-1:0]  set_idx;
        logic [BYTE_W-1:0] set_val;
    } ctrl_st_t;
endpackage

// File: rtl/rtcf_ctrl.sv
module rtcf_ctrl
    import rtcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_wr_start,
    input  logic              ev_rd_start,
    input  logic              ev_stop,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_req,
    output logic [PTR_W-1:0]  ptr,
    output logic              loc_we,
    output logic              snap_en,
    output logic              rd_en,
    output logic              set_stb,
    output logic [IDX_W-1:0]  set_idx,
    output logic [BYTE_W-1:0] set_val,
    output logic [PTR_W-1:0]  fmt_code
);
    localparam logic [PTR_W-1:0] TIME_LIM = PTR_W'(TIME_REGS);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.set_stb = 1'b0;
        loc_we       = 1'b0;
        snap_en      = 1'b0;
        rd_en        = 1'b0;
        if (ev_rd_start) begin
            st_d.ptr = '1;
            snap_en  = 1'b1;
        end else if (ev_wr_start) begin
            st_d.pend = 1'b1;
        end else if (ev_stop) begin
            st_d.pend = 1'b0;
        end else if (wr_valid) begin
            if (st_q.pend) begin
                st_d.ptr  = wr_byte[BYTE_W-1 -: PTR_W];
                st_d.fmt  = wr_byte[PTR_W-1:0];
                st_d.pend = 1'b0;
            end else begin
                if (st_q.ptr < TIME_LIM) begin
                    st_d.set_stb = 1'b1;
                    st_d.set_idx = st_q.ptr[IDX_W-1:0];
                    st_d.set_val = wr_byte;
                end else begin
                    loc_we = 1'b1;
                end
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else if (rd_req) begin
            rd_en    = 1'b1;
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr      = st_q.ptr;
    assign set_stb  = st_q.set_stb;
    assign set_idx  = st_q.set_idx;
    assign set_val  = st_q.set_val;
    assign fmt_code = st_q.fmt;

    // R5
    rd_start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd_start |=> st_q.ptr == '1);
    // R2
    addr_byte_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && st_q.pend && !ev_rd_start && !ev_wr_start && !ev_stop)
        |=> (st_q.ptr == $past(wr_byte[BYTE_W-1 -: PTR_W])) && !st_q.set_stb);
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_rd_start && !ev_wr_start)
        |=> !st_q.pend && $stable(st_q.ptr));
    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_valid && !ev_rd_start && !ev_wr_start && !ev_stop && st_q.ptr == '1)
        |=> st_q.ptr == '0);
    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.set_stb |-> $past(wr_valid) && !$past(st_q.pend));
endmodule

// File: rtl/rtcf_regfile.sv
module rtcf_regfile
    import rtcf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PTR_W-1:0]            ptr,
    input  logic                        loc_we,
    input  logic                        snap_en,
    input  logic                        rd_en,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic [TIME_REGS*BYTE_W-1:0] live_time,
    output logic [BYTE_W-1:0]           rd_byte
);
    localparam int DEPTH = 1 << PTR_W;

    logic [BYTE_W-1:0] mem_d [DEPTH];
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        rd_d = rd_q;
        if (snap_en) begin
            for (int i = 0; i < TIME_REGS; i++) mem_d[i] = live_time[i*BYTE_W +: BYTE_W];
        end
        if (loc_we) mem_d[ptr] = wdata;
        if (rd_en)  rd_d = mem_q[ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            rd_q <= rd_d;
        end
    end

    assign rd_byte = rd_q;

    // R3
    local_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |=> mem_q[$past(ptr)] == $past(wdata));

    genvar g;
    generate
        for (g = 0; g < TIME_REGS; g++) begin : g_time
            // R6
            time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !snap_en |=> $stable(mem_q[g]));
        end
    endgenerate
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
    import rtcf_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ev_wr_start,
    input  logic                        ev_rd_start,
    input  logic                        ev_stop,
    input  logic                        wr_valid,
    input  logic [BYTE_W-1:0]           wr_byte,
    input  logic                        rd_req,
    output logic [BYTE_W-1:0]           rd_byte,
    input  logic [TIME_REGS*BYTE_W-1:0] live_time,
    output logic                        set_stb,
    output logic [IDX_W-1:0]            set_idx,
    output logic [BYTE_W-1:0]           set_val,
    output logic [PTR_W-1:0]            fmt_code,
    output logic [6:0]                  dev_addr
);
    logic [PTR_W-1:0] ptr;
    logic             loc_we, snap_en, rd_en;

    rtcf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start), .ev_stop(ev_stop),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .ptr(ptr), .loc_we(loc_we), .snap_en(snap_en), .rd_en(rd_en),
        .set_stb(set_stb), .set_idx(set_idx), .set_val(set_val),
        .fmt_code(fmt_code)
    );

    rtcf_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .ptr(ptr), .loc_we(loc_we), .snap_en(snap_en), .rd_en(rd_en),
        .wdata(wr_byte), .live_time(live_time), .rd_byte(rd_byte)
    );

    assign dev_addr = SLAVE_ADDR;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_byte));
    // R10
    rd_start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd_start |=> !set_stb);
endmodule

// File: tb/sim_rtc_regfront.sv
module sim_rtc_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_wr_start = 0, ev_rd_start = 0, ev_stop = 0, wr_valid = 0, rd_req = 0;
    logic [7:0]  wr_byte = 0;
    logic [55:0] live_time = 0;
    logic [7:0]  rd_byte;
    logic        set_stb;
    logic [2:0]  set_idx;
    logic [7:0]  set_val;
    logic [3:0]  fmt_code;
    logic [6:0]  dev_addr;

    int tests = 0, fails = 0;
    logic [7:0] mreg [16];
    logic [3:0] mptr;
    logic       mpend;

    always #10 clk = ~clk;

    rtc_regfront u0 (
        .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
        .ev_stop(ev_stop), .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .rd_byte(rd_byte), .live_time(live_time), .set_stb(set_stb), .set_idx(set_idx),
        .set_val(set_val), .fmt_code(fmt_code), .dev_addr(dev_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        ev_wr_start = 0; ev_rd_start = 0; ev_stop = 0; wr_valid = 0; rd_req = 0;
    endtask

    task automatic wr_start;
        ev_wr_start = 1; step(); mpend = 1;
    endtask

    task automatic stop_ev;
        ev_stop = 1; step(); mpend = 0;
    endtask

    task automatic rd_start;
        ev_rd_start = 1; step();
        for (int k = 0; k < 7; k++) mreg[k] = live_time[k*8 +: 8];
        mptr = 4'hF;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_valid = 1; wr_byte = b; step();
        if (mpend) begin
            chk("R2 fmt", fmt_code, b[3:0]);
            chk("R2 no strobe", set_stb, 0);
            mptr = b[7:4]; mpend = 0;
        end else if (mptr < 7) begin
            chk("R4 strobe", set_stb, 1);
            chk("R4 idx", set_idx, mptr);
            chk("R4 val", set_val, b);
            mptr = mptr + 1;
        end else begin
            chk("R3 no strobe", set_stb, 0);
            mreg[mptr] = b; mptr = mptr + 1;
        end
    endtask

    task automatic rd(input string req);
        rd_req = 1; step();
        chk(req, rd_byte, mreg[mptr]);
        mptr = mptr + 1;
    endtask

    initial begin
        #4_000_000;
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) mreg[k] = 0;
        mptr = 0; mpend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset outputs
        chk("R1 rd_byte", rd_byte, 0);
        chk("R1 set_stb", set_stb, 0);
        chk("R1 fmt", fmt_code, 0);
        chk("R1 addr", dev_addr, 7'h32);
        // R1: pointer 0, nothing pending -> data byte goes to field 0
        wr(8'hA5);
        step();
        chk("R4 one cycle", set_stb, 0);
        // R5/R1: capture and read all 16, registers 7..15 are zero
        live_time = 56'h23_11_28_03_15_45_30;
        rd_start();
        for (int k = 0; k < 16; k++) rd("R1 R5 R9 read");
        // R2/R3/R4: sweep every pointer
        for (int p = 0; p < 16; p++) begin
            wr_start();
            wr({p[3:0], p[3:0] ^ 4'h9});
            wr(8'(p * 17 + 3));
        end
        // R7: write burst across the wrap
        wr_start();
        wr(8'hE6);
        wr(8'h5E); wr(8'h6F); wr(8'h70);
        // R5 R6 R7: capture, then change live values mid-read
        live_time = 56'h24_12_31_06_23_59_58;
        rd_start();
        live_time = 56'hFF_FF_FF_FF_FF_FF_FF;
        for (int k = 0; k < 17; k++) rd("R6 R7 snapshot read");
        // R8: stop clears pending, pointer kept
        wr_start(); wr(8'h90);
        wr_start(); stop_ev();
        wr(8'h77);
        chk("R8 pointer kept", mptr, 10);
        wr_start(); wr(8'h90);
        rd("R8 R3 readback");
        // R10: coincident start-for-read and data byte
        wr_start(); wr(8'h20);
        ev_rd_start = 1; wr_valid = 1; wr_byte = 8'h11; step();
        chk("R10 no strobe", set_stb, 0);
        for (int k = 0; k < 7; k++) mreg[k] = live_time[k*8 +: 8];
        mptr = 4'hF;
        rd("R10 ptr forced");
        rd("R10 snapshot");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule